// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block holds the configuration state of a small, fixed set of hardware debug triggers on behalf of a processor core. Software and an external debugger reach every trigger through one index register and a shared window of three data registers, so the core's CSR port only ever sees six addresses. A request is presented for one cycle with the current privilege level and a Debug Mode flag. The answer (read data and an illegal-access flag) comes back registered one cycle later.

Every write is legalized before it is stored. An index that names no trigger is replaced so that a read-back shows the mismatch. A trigger can be locked so that only Debug Mode may change it. The chain bit is kept consistent with the lock bits of the neighbouring triggers. An unsupported type code leaves the old type in place. A machine-mode trigger enable is pushed on trap entry and popped on trap return. Per-trigger permit outputs gate triggers whose action is zero while the hart runs in machine mode with that enable cleared. The address and data comparison and the entry into Debug Mode live outside this block.

Top module: `trig_csr_bank`

## Requirements
- R1: A write to the index register (0x7a0) with a value below NUM_TRIG stores that value. A value at or above NUM_TRIG stores NUM_TRIG, or NUM_TRIG+1 when exactly NUM_TRIG was written, so the read-back never equals an out-of-range write.
- R2: The type-info register (0x7a4) returns the selected trigger's support mask, with bit N set when type code N is supported. It returns 1 when the index names no trigger. With such an index, the data registers read 0 and writes to them are dropped.
- R3: Bits [31:28] of data register 1 (0x7a1) hold the type: 0 none, 2 address/data match, 3 instruction count, 4 interrupt, 5 exception, 15 present but unavailable. A written code that is 0 or not in the trigger's mask keeps the old type. Every trigger resets to type 2 with all other bits 0.
- R4: The lock bit is bit 27 of data register 1 and changes only on writes made in Debug Mode. While it is 1, writes from outside Debug Mode to data registers 1, 2 and 3 (0x7a1..0x7a3) of that trigger are dropped without an illegal flag.
- R5: When a data-register-1 write leaves the lock bit at 0 and the next trigger is locked, the written chain bit (bit 11) is stored as 0.
- R6: A data-register-1 write that would change the lock bit from 0 to 1 is dropped entirely when the previous trigger is unlocked with its chain bit set.
- R7: The control register (0x7a5) holds the machine-mode enable in bit 0 and its saved copy in bit 1, both reset to 0. A trap strobe copies bit 0 into bit 1 and clears bit 0. A return strobe copies bit 1 into bit 0.
- R8: A trap or return strobe takes priority over a control-register write in the same cycle. A trap strobe takes priority over a return strobe in the same cycle.
- R9: `fire_ok[i]` is 0 exactly when the hart is outside Debug Mode, the privilege is machine (3), the enable bit is 0 and bits [15:12] of trigger i are 0.
- R10: A request from privilege 0 or 1 outside Debug Mode, a request to an address outside 0x7a0..0x7a5, and a write to 0x7a4 return the illegal flag and change no state.
- R11: Every request gets `rsp_valid` in the following cycle. For a legal read, `rsp_rdata` carries the register value from before that cycle's updates. For writes and illegal requests it carries 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | CSR request strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | CSR address |
| wdata | input | XLEN | Write data |
| priv | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| dbg | input | 1 | Hart is in Debug Mode |
| trap | input | 1 | One-cycle strobe: trap taken into machine mode |
| mret | input | 1 | One-cycle strobe: return from machine-mode trap |
| rsp_valid | output | 1 | Response valid, one cycle after req |
| rsp_illegal | output | 1 | Request was refused |
| rsp_rdata | output | XLEN | Read data |
| fire_ok | output | NUM_TRIG | Per-trigger permit for the matching logic |

## Verification
The trap and return strobes can fall in the same cycle as a CSR write to the control register, and the two strobes can fall in the same cycle as each other. The bench drives each strobe in the same cycle as a conflicting control-register write, and also drives both strobes together. In each case it reads the control register back and expects the value the strobe alone would give, not the written data. The checker also asserts that the enable bit is 0 after any trap that coincided with such a write.

// File: rtl/trig_csr_pkg.sv
package trig_csr_pkg;

  localparam logic [11:0] A_SEL  = 12'h7a0;
  localparam logic [11:0] A_TD1  = 12'h7a1;
  localparam logic [11:0] A_TD2  = 12'h7a2;
  localparam logic [11:0] A_TD3  = 12'h7a3;
  localparam logic [11:0] A_INFO = 12'h7a4;
  localparam logic [11:0] A_CTL  = 12'h7a5;

  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  // field placement inside data register 1 (below the type and lock bits)
  localparam int CHAIN_BIT = 11;
  localparam int ACT_LO    = 12;
  localparam int ACT_W     = 4;
  localparam int TYPE_W    = 4;
  localparam int INFO_W    = 16;

  // control register bits
  localparam int CTL_EN   = 0;
  localparam int CTL_SAVE = 1;

  typedef enum logic [2:0] {
    RG_SEL, RG_TD1, RG_TD2, RG_TD3, RG_INFO, RG_CTL, RG_BAD
  } csr_reg_e;

  function automatic csr_reg_e decode_addr(input logic [11:0] a);
    csr_reg_e r;
    case (a)
      A_SEL:   r = RG_SEL;
      A_TD1:   r = RG_TD1;
      A_TD2:   r = RG_TD2;
      A_TD3:   r = RG_TD3;
      A_INFO:  r = RG_INFO;
      A_CTL:   r = RG_CTL;
      default: r = RG_BAD;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/trig_sel_reg.sv
module trig_sel_reg #(
  parameter int NUM_TRIG = 4,
  parameter int XLEN     = 32,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [XLEN-1:0]  wdata,
  output logic [SEL_W-1:0] sel,
  output logic             sel_ok
);

  localparam logic [XLEN-1:0]  LIMIT_X = XLEN'(NUM_TRIG);
  localparam logic [SEL_W-1:0] PARK_A  = SEL_W'(NUM_TRIG);
  localparam logic [SEL_W-1:0] PARK_B  = SEL_W'(NUM_TRIG + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
    end else if (wr_en) begin
      if (wdata < LIMIT_X) begin
        sel <= wdata[SEL_W-1:0];
      end else if (wdata == LIMIT_X) begin
        sel <= PARK_B;
      end else begin
        sel <= PARK_A;
      end
    end
  end

  assign sel_ok = (sel < PARK_A);

endmodule

// File: rtl/trig_ctl_reg.sv
module trig_ctl_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_en_bit,
  input  logic wr_save_bit,
  input  logic trap,
  input  logic mret,
  output logic en,
  output logic save
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      save <= 1'b0;
    end else if (trap) begin
      save <= en;
      en   <= 1'b0;
    end else if (mret) begin
      en   <= save;
    end else if (wr_en) begin
      en   <= wr_en_bit;
      save <= wr_save_bit;
    end
  end

endmodule

// File: rtl/trig_wr_legal.sv
module trig_wr_legal
  import trig_csr_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int XLEN     = 32,
  parameter int IDX_W    = 2,
  parameter logic [NUM_TRIG*INFO_W-1:0] TYPE_SUPPORT = '1
) (
  input  logic [IDX_W-1:0]               idx,
  input  logic [XLEN-1:0]                wdata,
  input  logic                           dbg,
  input  logic [NUM_TRIG-1:0][XLEN-1:0]  td1_q,
  input  logic [NUM_TRIG-1:0]            lock_v,
  input  logic [NUM_TRIG-1:0]            chain_v,
  output logic                           td1_ok,
  output logic                           data_ok,
  output logic [XLEN-1:0]                td1_d
);

  localparam int LOCK_BIT = XLEN - TYPE_W - 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_TRIG - 1);

  logic [XLEN-1:0]   old_v;
  logic [INFO_W-1:0] supp;
  logic [TYPE_W-1:0] w_type, new_type;
  logic              old_lock, new_lock;
  logic [IDX_W-1:0]  prev_i, next_i;
  logic              prev_chains, next_locked;
  logic              keep_chain;
  logic [LOCK_BIT-1:0] low_bits;

  always_comb begin
    old_v    = td1_q[idx];
    supp     = TYPE_SUPPORT[idx*INFO_W +: INFO_W];
    w_type   = wdata[XLEN-1 -: TYPE_W];
    new_type = ((w_type != '0) && supp[w_type]) ? w_type : old_v[XLEN-1 -: TYPE_W];

    old_lock = old_v[LOCK_BIT];
    new_lock = dbg ? wdata[LOCK_BIT] : old_lock;

    prev_i      = (idx == '0) ? '0 : idx - 1'b1;
    next_i      = (idx == LAST) ? idx : idx + 1'b1;
    prev_chains = (idx != '0) && !lock_v[prev_i] && chain_v[prev_i];
    next_locked = (idx != LAST) && lock_v[next_i];

    keep_chain = wdata[CHAIN_BIT] && !(!new_lock && next_locked);
    low_bits   = wdata[LOCK_BIT-1:0];
    low_bits[CHAIN_BIT] = keep_chain;

    data_ok = !(old_lock && !dbg);
    td1_ok  = data_ok && !(new_lock && !old_lock && prev_chains);
    td1_d   = {new_type, new_lock, low_bits};
  end

endmodule

// File: rtl/trig_slot.sv
module trig_slot #(
  parameter int XLEN       = 32,
  parameter int RESET_TYPE = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            td1_we,
  input  logic            td2_we,
  input  logic            td3_we,
  input  logic [XLEN-1:0] td1_d,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] td1_q,
  output logic [XLEN-1:0] td2_q,
  output logic [XLEN-1:0] td3_q
);

  localparam logic [XLEN-1:0] TD1_RST = {4'(RESET_TYPE), {(XLEN-4){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      td1_q <= TD1_RST;
      td2_q <= '0;
      td3_q <= '0;
    end else begin
      if (td1_we) td1_q <= td1_d;
      if (td2_we) td2_q <= wdata;
      if (td3_we) td3_q <= wdata;
    end
  end

endmodule

// File: rtl/trig_csr_bank.sv
module trig_csr_bank
  import trig_csr_pkg::*;
#(
  parameter int NUM_TRIG   = 4,
  parameter int XLEN       = 32,
  parameter int RESET_TYPE = 2,
  parameter logic [NUM_TRIG*INFO_W-1:0] TYPE_SUPPORT =
    {16'h8004, {(NUM_TRIG-1){16'h003C}}}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic                we,
  input  logic [11:0]         addr,
  input  logic [XLEN-1:0]     wdata,
  input  logic [1:0]          priv,
  input  logic                dbg,
  input  logic                trap,
  input  logic                mret,
  output logic                rsp_valid,
  output logic                rsp_illegal,
  output logic [XLEN-1:0]     rsp_rdata,
  output logic [NUM_TRIG-1:0] fire_ok
);

  localparam int IDX_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
  localparam int SEL_W    = $clog2(NUM_TRIG + 2);
  localparam int LOCK_BIT = XLEN - TYPE_W - 1;

  csr_reg_e                    rsel;
  logic                        priv_ok, refuse, wr;
  logic [SEL_W-1:0]            sel;
  logic                        sel_ok;
  logic [IDX_W-1:0]            idx;
  logic                        mte, mpte;
  logic [NUM_TRIG-1:0][XLEN-1:0] td1_q, td2_q, td3_q;
  logic [NUM_TRIG-1:0]         lock_v, chain_v;
  logic                        td1_ok, data_ok;
  logic [XLEN-1:0]             td1_d;
  logic                        td1_hit, td2_hit, td3_hit;
  logic [XLEN-1:0]             rd_val;

  // request decode and access check
  assign rsel    = decode_addr(addr);
  assign priv_ok = dbg || (priv == PRV_M);
  assign refuse  = !priv_ok || (rsel == RG_BAD) || (we && rsel == RG_INFO);
  assign wr      = req && we && !refuse;
  assign idx     = sel[IDX_W-1:0];

  trig_sel_reg #(.NUM_TRIG(NUM_TRIG), .XLEN(XLEN), .SEL_W(SEL_W)) i_sel (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr && rsel == RG_SEL),
    .wdata  (wdata),
    .sel    (sel),
    .sel_ok (sel_ok)
  );

  trig_ctl_reg i_ctl (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr && rsel == RG_CTL),
    .wr_en_bit   (wdata[CTL_EN]),
    .wr_save_bit (wdata[CTL_SAVE]),
    .trap        (trap),
    .mret        (mret),
    .en          (mte),
    .save        (mpte)
  );

  trig_wr_legal #(
    .NUM_TRIG(NUM_TRIG), .XLEN(XLEN), .IDX_W(IDX_W), .TYPE_SUPPORT(TYPE_SUPPORT)
  ) i_legal (
    .idx     (idx),
    .wdata   (wdata),
    .dbg     (dbg),
    .td1_q   (td1_q),
    .lock_v  (lock_v),
    .chain_v (chain_v),
    .td1_ok  (td1_ok),
    .data_ok (data_ok),
    .td1_d   (td1_d)
  );

  assign td1_hit = wr && sel_ok && (rsel == RG_TD1) && td1_ok;
  assign td2_hit = wr && sel_ok && (rsel == RG_TD2) && data_ok;
  assign td3_hit = wr && sel_ok && (rsel == RG_TD3) && data_ok;

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_slot
    trig_slot #(.XLEN(XLEN), .RESET_TYPE(RESET_TYPE)) i_slot (
      .clk    (clk),
      .rst    (rst),
      .td1_we (td1_hit && (idx == IDX_W'(i))),
      .td2_we (td2_hit && (idx == IDX_W'(i))),
      .td3_we (td3_hit && (idx == IDX_W'(i))),
      .td1_d  (td1_d),
      .wdata  (wdata),
      .td1_q  (td1_q[i]),
      .td2_q  (td2_q[i]),
      .td3_q  (td3_q[i])
    );
    assign lock_v[i]  = td1_q[i][LOCK_BIT];
    assign chain_v[i] = td1_q[i][CHAIN_BIT];
    // action-0 triggers are held off in machine mode while the enable is clear
    assign fire_ok[i] = dbg || (priv != PRV_M) || mte ||
                        (td1_q[i][ACT_LO +: ACT_W] != '0);
  end

  // read mux
  always_comb begin
    rd_val = '0;
    case (rsel)
      RG_SEL:  rd_val = XLEN'(sel);
      RG_TD1:  rd_val = sel_ok ? td1_q[idx] : '0;
      RG_TD2:  rd_val = sel_ok ? td2_q[idx] : '0;
      RG_TD3:  rd_val = sel_ok ? td3_q[idx] : '0;
      RG_INFO: rd_val = sel_ok ? XLEN'(TYPE_SUPPORT[idx*INFO_W +: INFO_W]) : XLEN'(1);
      RG_CTL: begin
        rd_val[CTL_EN]   = mte;
        rd_val[CTL_SAVE] = mpte;
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid   <= req;
      rsp_illegal <= req && refuse;
      rsp_rdata   <= (req && !we && !refuse) ? rd_val : '0;
    end
  end

endmodule

// File: rtl/trig_csr_bank_chk.sv
module trig_csr_bank_chk
  import trig_csr_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int XLEN     = 32,
  parameter int SEL_W    = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                req,
  input logic                we,
  input logic [11:0]         addr,
  input logic [XLEN-1:0]     wdata,
  input logic [1:0]          priv,
  input logic                dbg,
  input logic                trap,
  input logic                mret,
  input logic                rsp_valid,
  input logic                rsp_illegal,
  input logic [SEL_W-1:0]    sel,
  input logic                mte,
  input logic                mpte,
  input logic [NUM_TRIG-1:0] lock_v,
  input logic [NUM_TRIG-1:0] chain_v
);

  a_r1_bad_index_exposed: assert property (@(posedge clk) disable iff (rst)
    (req && we && addr == A_SEL && (dbg || priv == PRV_M) && wdata >= XLEN'(NUM_TRIG))
    |=> (XLEN'(sel) != $past(wdata)));

  a_r7_trap_push: assert property (@(posedge clk) disable iff (rst)
    trap |=> (!mte && mpte == $past(mte)));

  a_r7_mret_pop: assert property (@(posedge clk) disable iff (rst)
    (mret && !trap) |=> (mte == $past(mpte) && mpte == $past(mpte)));

  a_r8_strobe_beats_write: assert property (@(posedge clk) disable iff (rst)
    (trap && req && we && addr == A_CTL) |=> !mte);

  a_r10_low_priv_refused: assert property (@(posedge clk) disable iff (rst)
    (req && !dbg && priv != PRV_M) |=> (rsp_valid && rsp_illegal));

  a_r10_low_priv_no_change: assert property (@(posedge clk) disable iff (rst)
    (req && !dbg && priv != PRV_M && !trap && !mret)
    |=> ($stable(sel) && $stable(lock_v) && $stable(chain_v) && $stable(mte) && $stable(mpte)));

  a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req |=> rsp_valid);

  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !req |=> !rsp_valid);

  for (genvar i = 0; i + 1 < NUM_TRIG; i++) begin : g_chain
    // R5 and R6 together keep an unlocked chaining trigger from feeding a locked one
    a_r5_chain_into_locked: assert property (@(posedge clk) disable iff (rst)
      !(!lock_v[i] && chain_v[i] && lock_v[i+1]));
  end

endmodule

bind trig_csr_bank trig_csr_bank_chk #(
  .NUM_TRIG(NUM_TRIG), .XLEN(XLEN), .SEL_W(SEL_W)
) i_trig_csr_bank_chk (
  .clk         (clk),
  .rst         (rst),
  .req         (req),
  .we          (we),
  .addr        (addr),
  .wdata       (wdata),
  .priv        (priv),
  .dbg         (dbg),
  .trap        (trap),
  .mret        (mret),
  .rsp_valid   (rsp_valid),
  .rsp_illegal (rsp_illegal),
  .sel         (sel),
  .mte         (mte),
  .mpte        (mpte),
  .lock_v      (lock_v),
  .chain_v     (chain_v)
);

// File: tb/test_trig_csr_bank.sv
module test_trig_csr_bank;

  localparam int NUM_TRIG = 4;
  localparam int XLEN     = 32;
  localparam logic [11:0] S = 12'h7a0, T1 = 12'h7a1, T2 = 12'h7a2,
                          T3 = 12'h7a3, I = 12'h7a4, C = 12'h7a5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, we = 1'b0, dbg = 1'b0, trap = 1'b0, mret = 1'b0;
  logic [11:0] addr = '0;
  logic [XLEN-1:0] wdata = '0;
  logic [1:0] priv = 2'd3;
  logic rsp_valid, rsp_illegal;
  logic [XLEN-1:0] rsp_rdata;
  logic [NUM_TRIG-1:0] fire_ok;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  trig_csr_bank #(.NUM_TRIG(NUM_TRIG), .XLEN(XLEN)) i_trig_csr_bank (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .priv(priv), .dbg(dbg), .trap(trap), .mret(mret),
    .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal), .rsp_rdata(rsp_rdata),
    .fire_ok(fire_ok)
  );

  typedef struct packed {
    logic        w;
    logic [11:0] a;
    logic [31:0] d;
    logic [1:0]  p;
    logic        g;
    logic        ill;
    logic [31:0] rd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 61;
  localparam vec_t VEC [NV] = '{
    '{1'b0, S,  32'h0,         2'd3, 1'b0, 1'b0, 32'h0,         4'd11}, // R11 reset index
    '{1'b0, T1, 32'h0,         2'd3, 1'b0, 1'b0, 32'h2000_0000, 4'd3},  // R3 reset type
    '{1'b0, I,  32'h0,         2'd3, 1'b0, 1'b0, 32'h0000_003C, 4'd2},  // R2
    '{1'b0, C,  32'h0,         2'd3, 1'b0, 1'b0, 32'h0,         4'd7},  // R7 reset
    '{1'b1, S,  32'h3,         2'd3, 1'b0, 1'b0, 32'h0,         4'd1},  // R1
    '{1'b0, S,  32'h0,         2'd3, 1'b0, 1'b0, 32'h3,         4'd1},  // R1
    '{1'b0, I,  32'h0,         2'd3, 1'b0, 1'b0, 32'h0000_8004, 4'd2},  // R2
    '{1'b1, T1, 32'h5000_0000, 2'd3, 1'b0, 1'b0, 32'h0,         4'd3},  // R3 unsupported
    '{1'b0, T1, 32'h0,         2'd3, 1'b0, 1'b0, 32'h2000_0000, 4'd3},
    '{1'b1, T1, 32'hF000_0001, 2'd3, 1'b0, 1'b0, 32'h0,         4'd3},  // R3 type 15
    '{1'b0, T1, 32'h0,         2'd3, 1'b0, 1'b0, 32'hF000_0001, 4'd3},
    '{1'b1, T1, 32'h0000_0002, 2'd3, 1'b0, 1'b0, 32'h0,         4'd3},  // R3 type 0 kept old
    '{1'b0, T1, 32'h0,         2'd3, 1'b0, 1'b0, 32'hF000_0002, 4'd3},
    '{1'b1, S,  32'h4,         2'd3, 1'b0, 1'b0, 32'h0,         4'd1},  // R1 exactly N
    '{1'b0, S,  32'h0,         2'd3, 1'b0, 1'b0, 32'h5,         4'd1},
    '{1'b0, I,  32'h0,         2'd3, 1'b0, 1'b0, 32'h1,         4'd2},  // R2 absent
    '{1'b0, T1, 32'h0,         2'd3, 1'b0, 1'b0, 32'h0,         4'd2},
    '{1'b1, T2, 32'hAAAA,      2'd3, 1'b1, 1'b0, 32'h0,         4'd2},  // R2 dropped
    '{1'b1, S,  32'h7,         2'd3, 1'b0, 1'b0, 32'h0,         4'd1},  // R1 above N
    '{1'b0, S,  32'h0,         2'd3, 1'b0, 1'b0, 32'h4,         4'd1},
    '{1'b1, S,  32'h0,         2'd3, 1'b0, 1'b0, 32'h0,         4'd1},
    '{1'b0, S,  32'h0,         2'd0, 1'b0, 1'b1, 32'h0,         4'd10}, // R10 user read
    '{1'b1, T1, 32'h2000_FFFF, 2'd1, 1'b0, 1'b1, 32'h0,         4'd10}, // R10 supervisor write
    '{1'b0, T1, 32'h0,         2'd3, 1'b0, 1'b0, 32'h2000_0000, 4'd10},
    '{1'b1, 12'h7a6, 32'h1,    2'd3, 1'b0, 1'b1, 32'h0,         4'd10}, // R10 unknown addr
    '{1'b1, I,  32'h0,         2'd3, 1'b0, 1'b1, 32'h0,         4'd10}, // R10 info write
    '{1'b1, T1, 32'h2800_0000, 2'd3, 1'b1, 1'b0, 32'h0,         4'd4},  // R4 lock
    '{1'b0, T1, 32'h0,         2'd3, 1'b0, 1'b0, 32'h2800_0000, 4'd4},
    '{1'b1, T1, 32'h2000_1000, 2'd3, 1'b0, 1'b0, 32'h0,         4'd4},
    '{1'b0, T1, 32'h0,         2'd3, 1'b0, 1'b0, 32'h2800_0000, 4'd4},
    '{1'b1, T2, 32'h1234,      2'd3, 1'b0, 1'b0, 32'h0,         4'd4},
    '{1'b0, T2, 32'h0,         2'd3, 1'b0, 1'b0, 32'h0,         4'd4},
    '{1'b1, T2, 32'hCAFE,      2'd3, 1'b1, 1'b0, 32'h0,         4'd4},
    '{1'b0, T2, 32'h0,         2'd3, 1'b1, 1'b0, 32'hCAFE,      4'd4},
    '{1'b1, T1, 32'h2000_0000, 2'd3, 1'b1, 1'b0, 32'h0,         4'd4},
    '{1'b0, T1, 32'h0,         2'd3, 1'b0, 1'b0, 32'h2000_0000, 4'd4},
    '{1'b1, T1, 32'h2800_0000, 2'd3, 1'b0, 1'b0, 32'h0,         4'd4},  // R4 M cannot lock
    '{1'b0, T1, 32'h0,         2'd3, 1'b0, 1'b0, 32'h2000_0000, 4'd4},
    '{1'b1, S,  32'h1,         2'd3, 1'b0, 1'b0, 32'h0,         4'd5},
    '{1'b1, T1, 32'h2800_0000, 2'd3, 1'b1, 1'b0, 32'h0,         4'd5},
    '{1'b1, S,  32'h0,         2'd3, 1'b0, 1'b0, 32'h0,         4'd5},
    '{1'b1, T1, 32'h2000_0800, 2'd3, 1'b1, 1'b0, 32'h0,         4'd5},  // R5 chain cleared
    '{1'b0, T1, 32'h0,         2'd3, 1'b0, 1'b0, 32'h2000_0000, 4'd5},
    '{1'b1, T1, 32'h2800_0800, 2'd3, 1'b1, 1'b0, 32'h0,         4'd5},  // R5 locked keeps chain
    '{1'b0, T1, 32'h0,         2'd3, 1'b0, 1'b0, 32'h2800_0800, 4'd5},
    '{1'b1, T1, 32'h2000_0800, 2'd3, 1'b1, 1'b0, 32'h0,         4'd5},
    '{1'b0, T1, 32'h0,         2'd3, 1'b0, 1'b0, 32'h2000_0000, 4'd5},
    '{1'b1, S,  32'h1,         2'd3, 1'b0, 1'b0, 32'h0,         4'd6},
    '{1'b1, T1, 32'h2000_0000, 2'd3, 1'b1, 1'b0, 32'h0,         4'd6},
    '{1'b1, S,  32'h0,         2'd3, 1'b0, 1'b0, 32'h0,         4'd6},
    '{1'b1, T1, 32'h2000_0800, 2'd3, 1'b0, 1'b0, 32'h0,         4'd5},
    '{1'b0, T1, 32'h0,         2'd3, 1'b0, 1'b0, 32'h2000_0800, 4'd5},
    '{1'b1, S,  32'h1,         2'd3, 1'b0, 1'b0, 32'h0,         4'd6},
    '{1'b1, T1, 32'h2800_0000, 2'd3, 1'b1, 1'b0, 32'h0,         4'd6},  // R6 blocked
    '{1'b0, T1, 32'h0,         2'd3, 1'b0, 1'b0, 32'h2000_0000, 4'd6},
    '{1'b1, T1, 32'h2000_0004, 2'd3, 1'b1, 1'b0, 32'h0,         4'd6},  // R6 unlocked write ok
    '{1'b0, T1, 32'h0,         2'd3, 1'b0, 1'b0, 32'h2000_0004, 4'd6},
    '{1'b1, C,  32'h1,         2'd3, 1'b0, 1'b0, 32'h0,         4'd7},
    '{1'b0, C,  32'h0,         2'd3, 1'b0, 1'b0, 32'h1,         4'd7},
    '{1'b1, C,  32'h0,         2'd0, 1'b0, 1'b1, 32'h0,         4'd10},
    '{1'b0, C,  32'h0,         2'd3, 1'b0, 1'b0, 32'h1,         4'd10}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, response is registered at the next rising edge,
  // sampled at the falling edge after it
  task automatic access(input string tag, input logic w, input logic [11:0] a,
                        input logic [31:0] d, input logic [1:0] p, input logic g,
                        input logic tr, input logic mr,
                        input logic ill, input logic [31:0] rd);
    req = 1'b1; we = w; addr = a; wdata = d; priv = p; dbg = g; trap = tr; mret = mr;
    @(negedge clk);
    req = 1'b0; we = 1'b0; trap = 1'b0; mret = 1'b0; priv = 2'd3; dbg = 1'b0;
    check({tag, " valid"},   32'(rsp_valid),   32'h1);
    check({tag, " illegal"}, 32'(rsp_illegal), 32'(ill));
    check({tag, " rdata"},   rsp_rdata,        rd);
  endtask

  task automatic strobe(input logic tr, input logic mr);
    trap = tr; mret = mr;
    @(negedge clk);
    trap = 1'b0; mret = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 no response after reset", 32'(rsp_valid), 32'h0);
    check("R9 reset permit in M-mode", 32'(fire_ok), 32'h0);

    for (int k = 0; k < NV; k++) begin
      access($sformatf("R%0d vector %0d", VEC[k].rq, k), VEC[k].w, VEC[k].a, VEC[k].d,
             VEC[k].p, VEC[k].g, 1'b0, 1'b0, VEC[k].ill, VEC[k].rd);
    end

    // enable=1 save=0 here
    strobe(1'b1, 1'b0);
    access("R7 after trap", 1'b0, C, 0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2);
    strobe(1'b0, 1'b1);
    access("R7 after mret", 1'b0, C, 0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'h3);
    access("R8 trap with write", 1'b1, C, 0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
    access("R8 trap won", 1'b0, C, 0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2);
    access("R8 mret with write", 1'b1, C, 0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
    access("R8 mret won", 1'b0, C, 0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'h3);
    strobe(1'b1, 1'b1);
    access("R8 trap beats mret", 1'b0, C, 0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2);

    // enable now 0; triggers 0 and 1 have action 0
    #1 check("R9 M-mode enable clear", 32'(fire_ok[1:0]), 32'h0);
    priv = 2'd0; #1;
    check("R9 user mode", 32'(fire_ok), 32'hF);
    priv = 2'd3; dbg = 1'b1; #1;
    check("R9 debug mode", 32'(fire_ok), 32'hF);
    dbg = 1'b0;
    @(negedge clk);
    access("R9 set action", 1'b1, T1, 32'h2000_1004, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    #1 check("R9 nonzero action", 32'(fire_ok[1:0]), 32'h2);
    @(negedge clk);
    strobe(1'b0, 1'b1);
    #1 check("R9 enable set", 32'(fire_ok), 32'hF);

    // reset again
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    access("R7 control after reset", 1'b0, C, 0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    access("R1 index after reset", 1'b0, S, 0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    access("R3 type after reset", 1'b0, T1, 0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2000_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule